// File: doc/BRIEF.md
# Programmable Multi-Standard CRC Engine

This block keeps a running cyclic redundancy checksum over data that a processor or a DMA engine writes into it. Software picks one of three common generator polynomials and loads a starting value. Four option bits control the data side and the result side separately. Two of them reverse the bit order or invert the bits of each incoming byte. The other two reverse or invert the checksum as it is presented on the sum output.

A data write may carry 8, 16 or 32 bits. The datapath takes in one byte per clock, starting with the least significant byte. The first byte is taken in on the clock edge that accepts the write. Any further bytes follow on the next edges, and `busy` stays high while they are pending. The bus master has to wait for `busy` to drop before it issues its next data or seed write. While `busy` is high, a mode write is stored and takes effect once the write in progress has finished.

The controller has two named states. `ST_IDLE` accepts register writes. It absorbs the first byte of a data write and moves to `ST_RUN` through the transition *wide write* when more bytes remain. An 8-bit write or any other write takes the transition *stay idle*. `ST_RUN` absorbs one stored byte per clock. It loops on itself (*continue*) while bytes remain. It returns to `ST_IDLE` through *last byte*, and on that edge any stored mode write takes effect.

Top module: `crc_engine`

## Requirements
- R1: Mode bits [1:0] select the polynomial. 0 selects 0x1021 on 16 bits, 1 selects 0x8005 on 16 bits, and 2 or 3 select 0x04C11DB7 on 32 bits. The update is bit-serial with the most significant bit first. In the 16-bit modes, sum[31:16] reads 0.
- R2: When mode bit 2 is set, the bit order of each input byte is reversed before the byte enters the update.
- R3: When mode bit 3 is set, each input byte is inverted after any reversal and before the update.
- R4: Mode bit 4 reverses the sum across the active width (16 or 32 bits). Mode bit 5 inverts the sum across the active width. Both act only on the sum output, not on the stored state.
- R5: A write to address 1 while idle loads the running state with wr_data. The state of the next data write starts from this value.
- R6: A write to address 2 carries one data item. wr_size 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. Bytes are taken least significant first, one per clock, and the first byte is taken on the accepting edge. After an 8-bit write, busy stays 0. After a 16-bit write, busy is high for 1 cycle, and after a 32-bit write for 3 cycles. The sum shows the final value from the cycle after the edge that absorbs the last byte.
- R7: A data or seed write made while busy is high is ignored.
- R8: A write to address 0 made while busy is high takes effect on the edge that absorbs the last byte, so the write in progress uses the old polynomial and input options. A mode write made while idle applies to the next data write.
- R9: After reset, the state is 0 and the mode is 0 (polynomial 0x1021, no options), so sum reads 0 and busy reads 0.
- R10: A checksum computed from the same bytes has the same value whether the bytes arrive as 32-bit, 16-bit or 8-bit writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 seed, 2 data, 3 unused |
| wr_size | input | 2 | Width of a data write: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits |
| wr_data | input | 32 | Write data |
| sum | output | 32 | Checksum after the output options |
| busy | output | 1 | High while bytes of an earlier data write remain |

## Verification
The hardest cases to reach are the writes that land while bytes of a wide write are still pending. These are a mode change, which must be stored until the last byte, and a data or seed write, which must be dropped. The bench reaches them by issuing a 32-bit write and then, with no wait, driving the next strobe in the following cycle, when `busy` is known to be high. It then checks the final sum against the model applied to only the four accepted bytes and the old mode. A further seed and byte check shows that the stored mode took effect.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;
    localparam int NARROW_W = 16;

    typedef enum logic [1:0] {
        POLY_CCITT = 2'd0,
        POLY_C16   = 2'd1,
        POLY_C32   = 2'd2,
        POLY_C32B  = 2'd3
    } poly_sel_e;

    typedef struct packed {
        logic      sum_cpl;
        logic      sum_rev;
        logic      din_cpl;
        logic      din_rev;
        poly_sel_e poly;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_SEED = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    function automatic logic poly_is_narrow(input poly_sel_e p);
        return (p == POLY_CCITT) || (p == POLY_C16);
    endfunction

    function automatic logic [CRC_W-1:0] poly_value(input poly_sel_e p);
        logic [CRC_W-1:0] v;
        unique case (p)
            POLY_CCITT: v = 32'h0000_1021;
            POLY_C16:   v = 32'h0000_8005;
            default:    v = 32'h04C1_1DB7;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/crc_byte_unit.sv
module crc_byte_unit
    import crc_pkg::*;
(
    input  logic [CRC_W-1:0]  state_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  mode_t             mode_i,
    output logic [CRC_W-1:0]  state_o
);

    logic [BYTE_W-1:0] shaped;
    logic [CRC_W-1:0]  gen;
    logic              narrow;

    // input shaping: reversal first, then inversion
    always_comb begin
        shaped = byte_i;
        if (mode_i.din_rev) begin
            for (int i = 0; i < BYTE_W; i++) begin
                shaped[i] = byte_i[BYTE_W-1-i];
            end
        end
        if (mode_i.din_cpl) begin
            shaped = ~shaped;
        end
    end

    assign narrow = poly_is_narrow(mode_i.poly);
    assign gen    = poly_value(mode_i.poly);

    // eight serial steps, msb of the shaped byte first
    always_comb begin
        logic [CRC_W-1:0] s;
        logic             top;
        s = state_i;
        if (narrow) begin
            s[CRC_W-1:NARROW_W] = '0;
        end
        for (int k = BYTE_W-1; k >= 0; k--) begin
            top = narrow ? s[NARROW_W-1] : s[CRC_W-1];
            s   = {s[CRC_W-2:0], 1'b0};
            if (narrow) begin
                s[CRC_W-1:NARROW_W] = '0;
            end
            if (top ^ shaped[k]) begin
                s = s ^ gen;
            end
        end
        state_o = s;
    end

endmodule

// File: rtl/crc_sum_view.sv
module crc_sum_view
    import crc_pkg::*;
(
    input  logic [CRC_W-1:0] state_i,
    input  mode_t            mode_i,
    output logic [CRC_W-1:0] sum_o
);

    logic [CRC_W-1:0] masked;
    logic [CRC_W-1:0] flipped;
    logic             narrow;

    assign narrow = poly_is_narrow(mode_i.poly);
    assign masked = narrow ? {{(CRC_W-NARROW_W){1'b0}}, state_i[NARROW_W-1:0]} : state_i;

    always_comb begin
        flipped = '0;
        if (narrow) begin
            for (int i = 0; i < NARROW_W; i++) begin
                flipped[i] = masked[NARROW_W-1-i];
            end
        end else begin
            for (int i = 0; i < CRC_W; i++) begin
                flipped[i] = masked[CRC_W-1-i];
            end
        end
    end

    always_comb begin
        logic [CRC_W-1:0] v;
        v = mode_i.sum_rev ? flipped : masked;
        if (mode_i.sum_cpl) begin
            v = v ^ (narrow ? {{(CRC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}} : {CRC_W{1'b1}});
        end
        sum_o = v;
    end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CRC_W-1:0]  sum,
    output logic              busy
);

    localparam int BYTES = DATA_W / BYTE_W;
    localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_REM = CNT_W'(BYTES - 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fsm_e;

    fsm_e              state_q, state_d;
    logic [CNT_W-1:0]  rem_q, rem_d, rem_init;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic [CRC_W-1:0]  crc_q, crc_d, crc_step;
    mode_t             mode_q, mode_d, pend_q, pend_d;
    logic [BYTE_W-1:0] byte_sel;
    logic              absorb;
    logic              data_wr, seed_wr, mode_wr, finishing;

    assign data_wr = wr_en && (reg_sel_e'(wr_addr) == REG_DATA);
    assign seed_wr = wr_en && (reg_sel_e'(wr_addr) == REG_SEED);
    assign mode_wr = wr_en && (reg_sel_e'(wr_addr) == REG_MODE);

    always_comb begin
        unique case (wr_size)
            2'd0:    rem_init = '0;
            2'd1:    rem_init = CNT_W'(1);
            default: rem_init = LAST_REM;
        endcase
    end

    // next state and byte selection
    always_comb begin
        state_d  = state_q;
        rem_d    = rem_q;
        sh_d     = sh_q;
        absorb   = 1'b0;
        byte_sel = wr_data[BYTE_W-1:0];
        unique case (state_q)
            ST_IDLE: begin
                if (data_wr) begin
                    absorb = 1'b1;
                    sh_d   = wr_data >> BYTE_W;
                    rem_d  = rem_init;
                    if (rem_init != '0) begin
                        state_d = ST_RUN;     // wide write
                    end
                end
            end
            ST_RUN: begin
                absorb   = 1'b1;
                byte_sel = sh_q[BYTE_W-1:0];
                sh_d     = sh_q >> BYTE_W;
                rem_d    = rem_q - CNT_W'(1);
                if (rem_q == CNT_W'(1)) begin
                    state_d = ST_IDLE;        // last byte
                end
            end
        endcase
    end

    assign finishing = (state_q == ST_RUN) && (rem_q == CNT_W'(1));

    crc_byte_unit u_step (
        .state_i (crc_q),
        .byte_i  (byte_sel),
        .mode_i  (mode_q),
        .state_o (crc_step)
    );

    always_comb begin
        if ((state_q == ST_IDLE) && seed_wr) begin
            crc_d = wr_data[CRC_W-1:0];
        end else if (absorb) begin
            crc_d = crc_step;
        end else begin
            crc_d = crc_q;
        end
        pend_d = mode_wr ? mode_t'(wr_data[MODE_W-1:0]) : pend_q;
        mode_d = ((state_q == ST_IDLE) || finishing) ? pend_d : mode_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            sh_q    <= '0;
            crc_q   <= '0;
            mode_q  <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            sh_q    <= sh_d;
            crc_q   <= crc_d;
            mode_q  <= mode_d;
            pend_q  <= pend_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_RUN:  busy = 1'b1;
        endcase
    end

    crc_sum_view u_view (
        .state_i (crc_q),
        .mode_i  (mode_q),
        .sum_o   (sum)
    );

    AST_BUSY_NEEDS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(data_wr && (wr_size != 2'd0))); // R6

    AST_MODE_FROZEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q)); // R8

    AST_SUM_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy && !wr_en)) |-> $stable(sum)); // R5

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        poly_is_narrow(mode_q.poly) |-> (sum[CRC_W-1:NARROW_W] == '0)); // R1

    AST_SEED_DROPPED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy && seed_wr) && !$past(busy, 2) && busy) |-> (crc_q != $past(wr_data[CRC_W-1:0]) || crc_q == $past(crc_step))); // R7

endmodule

// File: tb/crc_engine_test.sv
module crc_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] sum;
    logic        busy;

    int checks = 0;
    int fails = 0;
    logic [7:0] msg [16];

    always #2.5 clk = ~clk;

    crc_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_data(wr_data), .sum(sum), .busy(busy)
    );

    // {mode, seed, expected} for the nine-character check string
    localparam logic [69:0] VEC [4] = '{
        {6'h00, 32'h0000_FFFF, 32'h0000_29B1},
        {6'h00, 32'h0000_0000, 32'h0000_31C3},
        {6'h15, 32'h0000_0000, 32'h0000_BB3D},
        {6'h36, 32'hFFFF_FFFF, 32'hCBF4_3926}
    };

    function automatic logic [31:0] ref_crc(input logic [5:0] m, input logic [31:0] seed, input int n);
        int w;
        logic [31:0] p, s, mask, o;
        logic [7:0] b;
        logic fb;
        w    = (m[1:0] < 2) ? 16 : 32;
        p    = (m[1:0] == 0) ? 32'h1021 : (m[1:0] == 1) ? 32'h8005 : 32'h04C11DB7;
        mask = (w == 16) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        s    = seed & mask;
        for (int i = 0; i < n; i++) begin
            b = msg[i];
            if (m[2]) b = {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
            if (m[3]) b = ~b;
            for (int k = 7; k >= 0; k--) begin
                fb = s[w-1] ^ b[k];
                s  = (s << 1) & mask;
                if (fb) s = s ^ p;
            end
        end
        o = s;
        if (m[4]) begin
            o = '0;
            for (int i = 0; i < w; i++) o[i] = s[w-1-i];
        end
        if (m[5]) o = o ^ mask;
        return o;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] sz, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_size = sz; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            step();
        end
    endtask

    task automatic load_string();
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    endtask

    initial begin
        int bc;
        logic [31:0] e;
        load_string();
        repeat (3) step();
        // R9: reset values
        chk("R9 sum", sum, 32'h0);
        chk("R9 busy", {31'b0, busy}, 32'h0);
        rst_n = 1'b1;
        step();

        // table walk: 8-bit writes of the check string (R1..R5)
        for (int v = 0; v < 4; v++) begin
            wr(2'd0, 2'd0, {26'b0, VEC[v][69:64]});
            wr(2'd1, 2'd0, VEC[v][63:32]);
            for (int i = 0; i < 9; i++) wr(2'd2, 2'd0, {24'b0, msg[i]});
            chk("R1 R4 table", sum, VEC[v][31:0]);
            chk("R1 model", ref_crc(VEC[v][69:64], VEC[v][63:32], 9), VEC[v][31:0]);
        end

        // all option combos, mixed widths (R1 R2 R3 R4 R10)
        for (int p = 0; p < 3; p++) begin
            for (int o = 0; o < 16; o++) begin
                logic [5:0] m;
                m = {o[3:0], p[1:0]};
                wr(2'd0, 2'd0, {26'b0, m});
                wr(2'd1, 2'd0, 32'h5A5A_1234);
                wr(2'd2, 2'd2, 32'h3433_3231);
                wait_idle(bc);
                wr(2'd2, 2'd1, 32'h0000_3635);
                wait_idle(bc);
                wr(2'd2, 2'd1, 32'h0000_3837);
                wait_idle(bc);
                wr(2'd2, 2'd0, 32'h0000_0039);
                chk("R2 R3 R4 R10 combo", sum, ref_crc(m, 32'h5A5A_1234, 9));
            end
        end

        // R6: busy lengths per size and timing of the sum
        wr(2'd0, 2'd0, 32'h02);
        wr(2'd1, 2'd0, 32'hFFFF_FFFF);
        wr(2'd2, 2'd0, 32'h31);
        chk("R6 8-bit busy", {31'b0, busy}, 32'h0);
        msg[0] = 8'h31;
        chk("R6 8-bit sum", sum, ref_crc(6'h02, 32'hFFFF_FFFF, 1));
        wr(2'd1, 2'd0, 32'hFFFF_FFFF);
        wr(2'd2, 2'd1, 32'h0000_3231);
        wait_idle(bc);
        chk("R6 16-bit busy cycles", 32'(bc), 32'd1);
        msg[1] = 8'h32;
        chk("R6 16-bit sum", sum, ref_crc(6'h02, 32'hFFFF_FFFF, 2));
        wr(2'd1, 2'd0, 32'hFFFF_FFFF);
        wr(2'd2, 2'd3, 32'hDDCC_BBAA);
        wait_idle(bc);
        chk("R6 32-bit busy cycles", 32'(bc), 32'd3);
        msg[0] = 8'hAA; msg[1] = 8'hBB; msg[2] = 8'hCC; msg[3] = 8'hDD;
        chk("R6 lsb-first sum", sum, ref_crc(6'h02, 32'hFFFF_FFFF, 4));

        // R7: data and seed writes while busy are dropped
        wr(2'd1, 2'd0, 32'h1111_1111);
        wr(2'd2, 2'd2, 32'hDDCC_BBAA);
        wr(2'd2, 2'd0, 32'h0000_00FF);
        wr(2'd1, 2'd0, 32'h0000_0000);
        wait_idle(bc);
        chk("R7 writes while busy ignored", sum, ref_crc(6'h02, 32'h1111_1111, 4));

        // R8: mode change while busy deferred
        wr(2'd0, 2'd0, 32'h00);
        wr(2'd1, 2'd0, 32'h0000_FFFF);
        wr(2'd2, 2'd2, 32'hDDCC_BBAA);
        wr(2'd0, 2'd0, 32'h01);
        wait_idle(bc);
        chk("R8 old mode for pending bytes", sum, ref_crc(6'h00, 32'h0000_FFFF, 4));
        wr(2'd1, 2'd0, 32'h0);
        wr(2'd2, 2'd0, 32'h31);
        msg[0] = 8'h31;
        chk("R8 new mode after finish", sum, ref_crc(6'h01, 32'h0, 1));
        chk("R1 narrow upper zero", {16'b0, sum[31:16]}, 32'h0);

        // R5: seed reload restarts
        wr(2'd1, 2'd0, 32'h0000_ABCD);
        chk("R5 seed visible", sum, 32'h0000_ABCD);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule